// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Counter

This block is a twisted-ring counter of `WIDTH` flip-flops. Each enabled clock shifts the register one place toward the top bit. The complement of the top bit enters at bit 0. Starting from all zeros, ones fill the register from the bottom and then drain out through the top. The full cycle has 2·`WIDTH` codes.

A mode input shortens the cycle to 2·`WIDTH`−1 codes by skipping the all-zeros code. Next to the raw state, the block reports a phase index and a flag for codes that lie outside the active cycle.

Stray codes can come from upsets or from an explicit seed load. Without correction they would circulate forever in sequences of their own. With correction, any code found outside the active cycle on an enabled clock is replaced by the mode's reset code. A small reset synchronizer lets reset assert at once and release only on a clock edge.

Top module: `johnson_ring_ctr`

## Requirements
- R1: While reset is asserted, `state_o` holds the mode's reset code. In full mode (`mode_i`=0) the reset code is all zeros. In short mode (`mode_i`=1) it is bit 0 set and all other bits clear. The reset code appears as soon as `rst_ni` falls.
- R2: In full mode, an enabled clock on a legal code gives `{state[WIDTH-2:0], ~state[WIDTH-1]}`. From all zeros the register first returns to all zeros after exactly 2·`WIDTH` enabled clocks. After `WIDTH` enabled clocks it holds all ones.
- R3: In short mode, the code with only the top bit set is followed by the code with only bit 0 set. The cycle then has 2·`WIDTH`−1 codes, and all zeros never appears while counting.
- R4: With `en_i` low and `seed_ld_i` low, `state_o` keeps its value, including an illegal value.
- R5: `illegal_o` is high exactly when the ones of `state_o` do not form a single contiguous run touching bit 0 or bit `WIDTH-1`. In short mode it is also high for the all-zeros code. All ones and all zeros both count as such runs.
- R6: An enabled clock on an illegal code loads the mode's reset code. Recovery therefore takes one clock, well inside 2·`WIDTH`.
- R7: `phase_o` gives the position of the code in the active cycle. In full mode it is k, where all zeros is k=0, the code with the low k bits set is k (for k up to `WIDTH`), and the code with the low k−`WIDTH` bits clear and all others set is k. In short mode it is k−1. It is 0 whenever `illegal_o` is high.
- R8: `seed_ld_i` high loads `seed_val_i` into the state on the next clock, whatever `en_i` is and whatever the seed's legality.
- R9: After `rst_ni` rises, the state stays at the reset code through the first two rising clock edges. The third edge is the first that can count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| en_i | input | 1 | Count enable |
| mode_i | input | 1 | 0: 2·WIDTH-code cycle, 1: 2·WIDTH−1-code cycle |
| seed_ld_i | input | 1 | Load `seed_val_i` into the state |
| seed_val_i | input | WIDTH | Value to load |
| state_o | output | WIDTH | Ring register contents |
| phase_o | output | $clog2(2·WIDTH) | Position within the active cycle |
| illegal_o | output | 1 | State lies outside the active cycle |

## Verification
A corrupted ring register shows at the ports in the same cycle. `illegal_o` rises and `phase_o` drops to zero. On the next enabled clock the state must snap back to the reset code. A wrong shift or a missed skip shows as a state that differs from the reference sequence on the edge where it happens.

The bench walks both cycle lengths and loads illegal seeds in both modes. It also forces a mode change while the register holds all zeros, and it resets mid-count to watch the two held edges. Every output is compared against a behavioural model on every clock.

// File: rtl/jc_pkg.sv
package jc_pkg;
  typedef enum logic {
    JC_FULL  = 1'b0,
    JC_SHORT = 1'b1
  } jc_mode_e;

  localparam int JC_SYNC_STAGES = 2;
endpackage

// File: rtl/jc_rst_sync.sv
module jc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/jc_code_check.sv
module jc_code_check
  import jc_pkg::*;
#(
  parameter int WIDTH   = 6,
  parameter int PHASE_W = 4
) (
  input  logic [WIDTH-1:0]   code_i,
  input  jc_mode_e           mode_i,
  output logic               illegal_o,
  output logic [PHASE_W-1:0] phase_o
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [PHASE_W-1:0] TWO_N = PHASE_W'(2 * WIDTH);

  logic [WIDTH-2:0]   boundary;
  logic [CNT_W-1:0]   boundary_cnt;
  logic [CNT_W-1:0]   ones_cnt;
  logic               zero_code;
  logic               shape_ok;
  logic [PHASE_W-1:0] full_pos;

  // one flag per adjacent pair of stages that differ
  for (genvar g = 0; g < WIDTH - 1; g++) begin : g_boundary
    assign boundary[g] = code_i[g] ^ code_i[g+1];
  end

  always_comb begin
    boundary_cnt = '0;
    for (int i = 0; i < WIDTH - 1; i++) begin
      boundary_cnt = boundary_cnt + CNT_W'(boundary[i]);
    end
  end

  always_comb begin
    ones_cnt = '0;
    for (int i = 0; i < WIDTH; i++) begin
      ones_cnt = ones_cnt + CNT_W'(code_i[i]);
    end
  end

  assign zero_code = (ones_cnt == '0);
  assign shape_ok  = (boundary_cnt <= CNT_W'(1));

  // filling half counts ones, draining half counts from the far end
  always_comb begin
    if (code_i[0] || zero_code) begin
      full_pos = PHASE_W'(ones_cnt);
    end else begin
      full_pos = TWO_N - PHASE_W'(ones_cnt);
    end
  end

  always_comb begin
    illegal_o = !shape_ok || ((mode_i == JC_SHORT) && zero_code);
    if (illegal_o) begin
      phase_o = '0;
    end else if (mode_i == JC_SHORT) begin
      phase_o = full_pos - PHASE_W'(1);
    end else begin
      phase_o = full_pos;
    end
  end
endmodule

// File: rtl/jc_next_state.sv
module jc_next_state
  import jc_pkg::*;
#(
  parameter int WIDTH = 6
) (
  input  logic [WIDTH-1:0] state_i,
  input  jc_mode_e         mode_i,
  input  logic             illegal_i,
  input  logic             en_i,
  input  logic             seed_ld_i,
  input  logic [WIDTH-1:0] seed_val_i,
  input  logic [WIDTH-1:0] rst_code_i,
  output logic [WIDTH-1:0] state_d_o
);
  localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] LOW_ONLY = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] advance;

  assign shifted = {state_i[WIDTH-2:0], ~state_i[WIDTH-1]};

  // short cycle: jump over all-zeros straight to the first filled code
  always_comb begin
    if ((mode_i == JC_SHORT) && (state_i == TOP_ONLY)) begin
      advance = LOW_ONLY;
    end else begin
      advance = shifted;
    end
  end

  always_comb begin
    if (seed_ld_i) begin
      state_d_o = seed_val_i;
    end else if (en_i) begin
      state_d_o = illegal_i ? rst_code_i : advance;
    end else begin
      state_d_o = state_i;
    end
  end
endmodule

// File: rtl/johnson_ring_ctr.sv
module johnson_ring_ctr
  import jc_pkg::*;
#(
  parameter  int WIDTH   = 6,
  localparam int PHASE_W = $clog2(2 * WIDTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               mode_i,
  input  logic               seed_ld_i,
  input  logic [WIDTH-1:0]   seed_val_i,
  output logic [WIDTH-1:0]   state_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               illegal_o
);
  localparam logic [WIDTH-1:0] LOW_ONLY = {{(WIDTH-1){1'b0}}, 1'b1};

  jc_mode_e         mode;
  logic             rst_sync_n;
  logic [WIDTH-1:0] rst_code;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic             illegal;

  assign mode     = jc_mode_e'(mode_i);
  assign rst_code = (mode == JC_SHORT) ? LOW_ONLY : '0;

  jc_rst_sync #(
    .STAGES (JC_SYNC_STAGES)
  ) u_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_sync_n)
  );

  jc_code_check #(
    .WIDTH   (WIDTH),
    .PHASE_W (PHASE_W)
  ) u_check (
    .code_i    (state_q),
    .mode_i    (mode),
    .illegal_o (illegal),
    .phase_o   (phase_o)
  );

  jc_next_state #(
    .WIDTH (WIDTH)
  ) u_next (
    .state_i    (state_q),
    .mode_i     (mode),
    .illegal_i  (illegal),
    .en_i       (en_i),
    .seed_ld_i  (seed_ld_i),
    .seed_val_i (seed_val_i),
    .rst_code_i (rst_code),
    .state_d_o  (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= rst_code;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o   = state_q;
  assign illegal_o = illegal;

  a_r2_full_shift: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (mode == JC_FULL && en_i && !seed_ld_i && !illegal)
      |=> (state_q == {$past(state_q[WIDTH-2:0]), ~$past(state_q[WIDTH-1])}));

  a_r3_no_zero_short: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (mode == JC_SHORT && en_i && !seed_ld_i) |=> (state_q != '0));

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!en_i && !seed_ld_i) |=> $stable(state_q));

  a_r6_recover: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (en_i && !seed_ld_i && illegal) |=> ((mode_i != $past(mode_i)) || !illegal_o));

  a_r7_phase_zero: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    illegal_o |-> (phase_o == '0));

  a_r8_seed: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    seed_ld_i |=> (state_q == $past(seed_val_i)));
endmodule

// File: tb/tb_johnson_ring_ctr.sv
`timescale 1ns/1ps
module tb_johnson_ring_ctr;
  localparam int W  = 6;
  localparam int PW = $clog2(2 * W);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic          clk = 1'b0;
  logic          rst_n, en, mode, ld;
  logic [W-1:0]  val;
  logic [W-1:0]  state;
  logic [PW-1:0] phase;
  logic          illegal;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [W-1:0] model;

  always #4 clk = ~clk;

  johnson_ring_ctr #(.WIDTH(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode),
    .seed_ld_i(ld), .seed_val_i(val),
    .state_o(state), .phase_o(phase), .illegal_o(illegal)
  );

  function automatic logic [W-1:0] code_of(int k);
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = (k <= W) ? (i < k) : (i >= k - W);
    return v;
  endfunction

  function automatic int find_k(logic [W-1:0] s, logic m);
    for (int k = 0; k < 2 * W; k++)
      if (code_of(k) == s && !(m && k == 0)) return k;
    return -1;
  endfunction

  function automatic logic [W-1:0] model_next(logic [W-1:0] s, logic m, logic e,
                                              logic l, logic [W-1:0] v);
    int k, kn;
    if (l) return v;
    if (!e) return s;
    k = find_k(s, m);
    if (k < 0) return m ? ONE : '0;
    kn = (k + 1) % (2 * W);
    if (m && kn == 0) kn = 1;
    return code_of(kn);
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    int k;
    k = find_k(model, mode);
    check(tag, int'(state), int'(model));
    check("R5", int'(illegal), int'(k < 0));
    check("R7", int'(phase), (k < 0) ? 0 : (mode ? k - 1 : k));
  endtask

  // drive at negedge, clock once, compare at the next negedge
  task automatic step(logic e, logic l, logic [W-1:0] v, string tag);
    logic [W-1:0] nxt;
    en = e; ld = l; val = v;
    nxt = model_next(model, mode, e, l, v);
    @(posedge clk);
    @(negedge clk);
    model = nxt;
    compare(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] seeds [6];
    bit saw_zero;
    seeds = '{6'b010010, 6'b101010, 6'b011000, 6'b100001, 6'b110011, 6'b001100};
    rst_n = 1'b0; en = 1'b0; mode = 1'b0; ld = 1'b0; val = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    model = '0;
    compare("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: full cycle of 2W codes
    for (int i = 1; i <= 2 * W; i++) begin
      step(1'b1, 1'b0, '0, "R2");
      if (i == W) check("R2", int'(state), int'({W{1'b1}}));
      if (i < 2 * W && state == '0) check("R2", 1, 0);
    end
    check("R2", int'(state), 0);

    // R4: enable gaps
    for (int i = 0; i < 10; i++) step(i % 3 != 0, 1'b0, '0, "R4");

    // R5/R6: all zeros becomes illegal when switching to short mode
    step(1'b0, 1'b1, '0, "R8");
    mode = 1'b1;
    step(1'b0, 1'b0, '0, "R4");
    check("R5", int'(illegal), 1);
    step(1'b1, 1'b0, '0, "R6");
    check("R6", int'(state), int'(ONE));

    // R3: short cycle of 2W-1 codes
    saw_zero = 0;
    for (int i = 1; i <= 2 * W - 1; i++) begin
      step(1'b1, 1'b0, '0, "R3");
      if (state == '0) saw_zero = 1;
      if (i < 2 * W - 1 && state == ONE) check("R3", 1, 0);
    end
    check("R3", int'(state), int'(ONE));
    check("R3", int'(saw_zero), 0);
    step(1'b0, 1'b1, {1'b1, {(W-1){1'b0}}}, "R8");
    step(1'b1, 1'b0, '0, "R3");
    check("R3", int'(state), int'(ONE));

    // R6/R8: illegal seeds in both modes
    for (int m = 1; m >= 0; m--) begin
      mode = 1'(m);
      foreach (seeds[j]) begin
        step(1'b0, 1'b1, seeds[j], "R8");
        check("R5", int'(illegal), 1);
        step(1'b0, 1'b0, '0, "R4");
        step(1'b1, 1'b0, '0, "R6");
        check("R6", int'(illegal), 0);
        step(1'b1, 1'b0, '0, "R2");
      end
    end

    // R8: load wins over enable
    step(1'b1, 1'b1, 6'b111000, "R8");
    check("R8", int'(state), int'(6'b111000));
    step(1'b1, 1'b0, '0, "R2");

    // R1/R9: reset mid-run in short mode, synchronized release
    mode = 1'b1;
    en = 1'b1; ld = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1", int'(state), int'(ONE));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9", int'(state), int'(ONE));
    @(posedge clk); @(negedge clk);
    check("R9", int'(state), int'(ONE));
    @(posedge clk); @(negedge clk);
    check("R9", int'(state), int'(code_of(2)));
    model = code_of(2);
    for (int i = 0; i < 2 * W; i++) step(1'b1, 1'b0, '0, "R3");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule